// File: doc/BRIEF.md
# Multi-Frame D-Channel Byte Packer

This block sits on a time-division serial line where each frame carries two signalling bits in a dedicated slot. On the receive side it gathers those two bits from each of four consecutive frames into one 8-bit byte. It presents that byte with a single-cycle valid pulse. On the transmit side it does the reverse: a byte placed in a holding register is cut into four two-bit pieces and driven onto the line, one piece per frame.

A format input selects the bit ordering. In HDLC mode the line is lsb-first and the byte is right-aligned. In unencoded mode the line is msb-first and the byte is left-aligned. The format is taken only at a four-frame boundary, so a byte is never assembled with mixed ordering. A realign input restarts the four-frame count, which lets the byte boundary be moved to a chosen frame. HDLC framing, flag detection and bit stuffing are handled elsewhere.

Top module: `dchan_packer`

## Requirements
- R1: In reset, and in the first cycle after it, the outputs are as follows: `rx_valid` is 0, `rx_data` is 0x00 and `tx_empty` is 1. `line_out` is 1, because the idle transmit byte is 0xFF.
- R2: The block takes exactly two D bits per frame, and a byte is complete after eight D bits spread over four frames. `rx_valid` is high for exactly one cycle: the cycle after the clock edge that samples the eighth bit. It is low at every other time.
- R3: With `order_lsb`=1 (HDLC), the k-th D bit of a group (k = 0..7) lands in `rx_data[k]`. Frame 0 fills bits 1:0 and frame 3 fills bits 7:6.
- R4: With `order_lsb`=0 (unencoded), the k-th D bit of a group lands in `rx_data[7-k]`. Frame 0 fills bits 7:6 and frame 3 fills bits 1:0.
- R5: During the k-th D slot of a group, `line_out` carries bit k of the current transmit byte in HDLC mode, and bit 7-k in unencoded mode.
- R6: Writing with `tx_wr` fills the holding register, and `tx_empty` reads 0 in the next cycle. The group boundary is the edge that samples the eighth D bit. At that edge the held byte becomes the transmit byte and `tx_empty` returns to 1. If nothing was held, the next group transmits 0xFF.
- R7: A `realign` pulse clears the frame and slot counters and drops any partial receive byte, and `rx_valid` stays low. The next D bit is bit 0 of a new group. The transmit byte is kept and restarts from its own bit 0.
- R8: `order_lsb` is latched only in reset, on `realign`, and at the group boundary. A change in the middle of a group affects neither that group's receive byte nor its transmit bits.
- R9: Values on `line_in` in cycles where `d_slot` is low have no effect on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame start pulse; restarts the in-frame D-bit count |
| d_slot | input | 1 | High in each of the two D-bit cycles of a frame |
| line_in | input | 1 | Serial receive data |
| order_lsb | input | 1 | 1 = lsb-first/right-aligned, 0 = msb-first/left-aligned |
| realign | input | 1 | Clears the four-frame count |
| tx_wr | input | 1 | Load `tx_data` into the holding register |
| tx_data | input | 8 | Byte to transmit |
| line_out | output | 1 | Serial transmit data, valid while `d_slot` is high |
| rx_data | output | 8 | Last assembled receive byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| tx_empty | output | 1 | Holding register is free |

## Verification
The assertions assume three things about the inputs:
- `d_slot` is never high in the same cycle as `frame_sync` or `realign`.
- Each frame opens with `frame_sync` before its two D slots.
- Writes to the holding register fall between group boundaries.

The stimulus keeps within these limits by building every frame from the same pattern: one sync cycle, two slot cycles, then gap cycles. Writes and realign pulses are issued only in gap cycles. Toggling data is driven in every non-slot cycle to exercise R9.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/dpk_slot_counter.sv
module dpk_slot_counter #(
  parameter int FRAMES         = 4,
  parameter int BITS_PER_FRAME = 2,
  parameter int IDX_W          = $clog2(FRAMES * BITS_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sync,
  input  logic             d_slot,
  input  logic             realign,
  input  logic             order_lsb,
  output logic             take,
  output logic             last,
  output logic [IDX_W-1:0] pos
);
  import dpk_pkg::*;

  localparam int BYTE_W = FRAMES * BITS_PER_FRAME;
  localparam int FW     = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int SW     = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1;

  logic [FW-1:0]    frame_q;
  logic [SW-1:0]    sub_q, sub_eff;
  logic [IDX_W-1:0] slot_idx;
  order_e           order_q;

  always_comb begin
    sub_eff  = frame_sync ? '0 : sub_q;
    slot_idx = IDX_W'(frame_q) * IDX_W'(BITS_PER_FRAME) + IDX_W'(sub_eff);
    take     = d_slot && !realign && !rst;
    last     = take && (frame_q == FW'(FRAMES - 1)) && (sub_eff == SW'(BITS_PER_FRAME - 1));
    pos      = (order_q == ORDER_LSB_FIRST) ? slot_idx : IDX_W'(BYTE_W - 1) - slot_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || realign) begin
      frame_q <= '0;
      sub_q   <= '0;
      order_q <= order_e'(order_lsb);
    end else begin
      if (frame_sync) sub_q <= '0;
      if (take) begin
        if (sub_eff == SW'(BITS_PER_FRAME - 1)) begin
          sub_q   <= '0;
          frame_q <= (frame_q == FW'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
        end else begin
          sub_q <= sub_eff + 1'b1;
        end
      end
      if (last) order_q <= order_e'(order_lsb);
    end
  end

  // R8: the ordering latch moves only at reset, realign or a group boundary
  assert_order_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(order_q) |-> $past(last || realign || rst));

  // R2: the frame counter steps only on a taken D bit
  assert_frame_steps_on_take_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(frame_q) && !$past(realign || rst)) |-> $past(take));
endmodule

// File: rtl/dpk_rx_assembler.sv
module dpk_rx_assembler #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              realign,
  input  logic              take,
  input  logic              last,
  input  logic [IDX_W-1:0]  pos,
  input  logic              din,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [BYTE_W-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt      = acc_q;
    acc_nxt[pos] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
    end else if (last) begin
      rx_data <= acc_nxt;
    end
    if (rst || realign) begin
      acc_q    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last;
      if (take) acc_q <= acc_nxt;
    end
  end

  // R2: a byte is announced for a single cycle only
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R2: an announcement always follows a sampled D bit
  assert_valid_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(take));
endmodule

// File: rtl/dpk_tx_serializer.sv
module dpk_tx_serializer #(
  parameter int              BYTE_W = 8,
  parameter int              IDX_W  = $clog2(BYTE_W),
  parameter logic [BYTE_W-1:0] IDLE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last,
  input  logic [IDX_W-1:0]  pos,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              line_out,
  output logic              tx_empty
);
  logic [BYTE_W-1:0] cur_q, hold_q;
  logic              full_q;

  assign line_out = cur_q[pos];
  assign tx_empty = !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= IDLE;
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (last) cur_q <= full_q ? hold_q : IDLE;
      if (tx_wr) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end else if (last) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6: a write always leaves the holding register occupied
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_empty);

  // R6: a boundary without a write frees the holding register
  assert_boundary_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (last && !tx_wr) |=> tx_empty);
endmodule

// File: rtl/dchan_packer.sv
module dchan_packer #(
  parameter int FRAMES         = 4,
  parameter int BITS_PER_FRAME = 2,
  parameter int BYTE_W         = FRAMES * BITS_PER_FRAME
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              d_slot,
  input  logic              line_in,
  input  logic              order_lsb,
  input  logic              realign,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              line_out,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_empty
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic             take, last;
  logic [IDX_W-1:0] pos;

  dpk_slot_counter #(
    .FRAMES(FRAMES), .BITS_PER_FRAME(BITS_PER_FRAME), .IDX_W(IDX_W)
  ) slot_i (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .d_slot(d_slot),
    .realign(realign), .order_lsb(order_lsb),
    .take(take), .last(last), .pos(pos)
  );

  dpk_rx_assembler #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) rx_i (
    .clk(clk), .rst(rst), .realign(realign), .take(take), .last(last),
    .pos(pos), .din(line_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  dpk_tx_serializer #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .IDLE({BYTE_W{1'b1}})) tx_i (
    .clk(clk), .rst(rst), .last(last), .pos(pos), .tx_wr(tx_wr),
    .tx_data(tx_data), .line_out(line_out), .tx_empty(tx_empty)
  );

  // R7: a realign pulse never produces a byte announcement
  assert_realign_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    realign |=> !rx_valid);
endmodule

// File: tb/dchan_packer_tb_top.sv
module dchan_packer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_sync = 1'b0, d_slot = 1'b0, line_in = 1'b0;
  logic       order_lsb = 1'b1, realign = 1'b0, tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       line_out, rx_valid, tx_empty;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the transmit side and the latched ordering
  logic       m_grp;
  logic [7:0] m_cur, m_hold;
  bit         m_hv;
  logic [7:0] garb = 8'h5D;

  always #2 clk = ~clk;  // 250 MHz

  dchan_packer dut_i (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .d_slot(d_slot),
    .line_in(line_in), .order_lsb(order_lsb), .realign(realign),
    .tx_wr(tx_wr), .tx_data(tx_data), .line_out(line_out),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_empty(tx_empty)
  );

  function automatic logic sbit(input logic [7:0] v, input logic lsb, input int k);
    return lsb ? v[k] : v[7-k];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic fs, input logic ds, input logic din);
    @(negedge clk);
    frame_sync = fs; d_slot = ds; line_in = din; tx_wr = 1'b0; realign = 1'b0;
    #1;
  endtask

  // gap-cycle data toggles so that ignored bits are exercised (R9)
  function automatic logic next_garb();
    garb = {garb[6:0], garb[7] ^ garb[5] ^ garb[4] ^ garb[3]};
    return garb[0];
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    frame_sync = 1'b0; d_slot = 1'b0; tx_wr = 1'b1; tx_data = v;
    @(negedge clk);
    tx_wr = 1'b0;
    #1;
    chk({7'd0, tx_empty}, 8'h00, "R6 write fills hold");
    m_hold = v; m_hv = 1;
  endtask

  task automatic send_group(input logic [7:0] rxv, input int flip_frame);
    for (int f = 0; f < 4; f++) begin
      if (f == flip_frame) order_lsb = ~order_lsb;
      drive(1'b1, 1'b0, next_garb());
      for (int s = 0; s < 2; s++) begin
        int k = 2 * f + s;
        drive(1'b0, 1'b1, sbit(rxv, m_grp, k));
        chk({7'd0, line_out}, {7'd0, sbit(m_cur, m_grp, k)}, "R5 line_out bit");
      end
      drive(1'b0, 1'b0, next_garb());
      if (f < 3) begin
        chk({7'd0, rx_valid}, 8'h00, "R2 no valid mid group");
      end else begin
        chk({7'd0, rx_valid}, 8'h01, "R2 valid after eighth bit");
        chk(rx_data, rxv, m_grp ? "R3 lsb-first byte" : "R4 msb-first byte");
        m_grp = order_lsb;
        m_cur = m_hv ? m_hold : 8'hFF;
        m_hv  = 0;
        chk({7'd0, tx_empty}, 8'h01, "R6 boundary frees hold");
        drive(1'b0, 1'b0, next_garb());
        chk({7'd0, rx_valid}, 8'h00, "R2 valid is one cycle");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({7'd0, rx_valid}, 8'h00, "R1 reset rx_valid");
    chk({7'd0, line_out}, 8'h01, "R1 reset line_out idle");
    @(negedge clk);
    rst = 1'b0;
    m_grp = 1'b1; m_cur = 8'hFF; m_hv = 0;
    #1;
    chk({7'd0, rx_valid}, 8'h00, "R1 rx_valid after reset");
    chk(rx_data, 8'h00, "R1 rx_data after reset");
    chk({7'd0, tx_empty}, 8'h01, "R1 tx_empty after reset");
    chk({7'd0, line_out}, 8'h01, "R1 line_out after reset");

    // exhaustive sweep in both orderings (R3, R4, R5, R6, R9)
    for (int m = 1; m >= 0; m--) begin
      order_lsb = m[0];
      send_group(8'h00, -1);  // idle 0xFF is transmitted here (R6)
      for (int v = 0; v < 256; v++) begin
        wr(~v[7:0]);
        send_group(v[7:0], -1);
      end
    end

    // R8: ordering flipped in frame 1 of a group applies only to the next group
    order_lsb = 1'b0;
    send_group(8'h11, -1);
    wr(8'hA6);
    send_group(8'hC5, 1);
    send_group(8'h3A, -1);

    // R7: partial group dropped by realign; ordering re-latched there too
    wr(8'h4B);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    chk({7'd0, line_out}, {7'd0, sbit(m_cur, m_grp, 0)}, "R5 line_out before realign");
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    order_lsb = ~order_lsb;
    @(negedge clk);
    realign = 1'b1; d_slot = 1'b0; frame_sync = 1'b0;
    @(negedge clk);
    realign = 1'b0;
    m_grp = order_lsb;
    #1;
    chk({7'd0, rx_valid}, 8'h00, "R7 no valid after realign");
    send_group(8'h96, -1);
    send_group(8'hE1, -1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule